// File: doc/BRIEF.md
# Framed synchronous sample serializer

This block moves sample words out of the logic towards a host over a three-wire synchronous link: a divided serial clock, a frame-sync line and a data line. Each word leaves most significant bit first, behind a single frame-sync pulse, with one word per frame. While a word is being sent, the host returns the same number of bits on a return line, and those bits come back as a parallel word.

The length of a word follows a mode field. One mode code, the high-frequency reader code, selects 16-bit words. Every other code selects 8-bit words, and those are taken from the low byte of the sample. The mode is read only at the moment a word starts, so a change never splits a word. Data and frame change on the rising edge of the serial clock so that the host can sample them on the falling edge. The block samples the return bits on that same falling edge.

A single holding slot takes the sample strobe. When the slot is full as the current word ends, the held word starts on the very next serial clock rise with no gap.

Top module: `sample_serializer`

## Requirements
- R1: `ser_clk` is the system clock divided by `DIV` (even, at least 2), with equal high and low halves. After reset it first rises in the `DIV`-th clock cycle.
- R2: While reset is applied and straight after it, `ser_clk`, `ser_frame`, `ser_dout` and `host_valid` are all 0.
- R3: Bits are sent most significant first. When `mode` equals `HF_MODE`, a word is 16 bits taken from `smp_word[15:0]`. Any other mode value gives an 8-bit word taken from `smp_word[7:0]`.
- R4: `ser_frame` is high for exactly one serial clock period, starting at the rise that presents the first bit of each word. There is exactly one frame pulse per word.
- R5: `ser_dout` and `ser_frame` change only in the system clock cycle in which `ser_clk` rises.
- R6: `mode` is sampled only at the rise that starts a word. A change in the middle of a word does not alter that word's length or bits.
- R7: When no word is in flight, `ser_dout` and `ser_frame` are held low.
- R8: One holding slot keeps the latest strobed word. A strobe that arrives before the held word has started replaces it. A held word starts on the first rise after the previous word's last bit period, with no idle period in between.
- R9: A return bit is sampled from `ser_din` at every falling edge of `ser_clk` during a word. After the falling edge of the last bit, `host_word` holds the bits, first bit most significant and zero-extended for 8-bit words, and `host_valid` is high for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_word | input | 16 | Parallel sample word |
| smp_valid | input | 1 | Strobe that loads `smp_word` into the holding slot |
| mode | input | MODE_W | Major mode field; `HF_MODE` selects 16-bit words |
| ser_din | input | 1 | Return data from the host |
| ser_clk | output | 1 | Divided serial clock |
| ser_frame | output | 1 | Frame-sync pulse, one per word |
| ser_dout | output | 1 | Serial data, MSB first |
| host_word | output | 16 | Parallel word received from the host |
| host_valid | output | 1 | One-cycle strobe marking a new `host_word` |

## Verification
On every cycle, the assertions check four things: data and frame move only on a serial clock rise, a frame never lasts past one serial clock period, the line stays quiet when no word is in flight, and the receive strobe is a single cycle placed in the low phase of the serial clock. The bench shows the rest by comparing every output on every cycle with a model built from queues. That covers the bit order, the word length chosen for each mode, a mode change in the middle of a word, replacement of the held word, back-to-back words with no gap, and the recovered return words.

// File: rtl/sample_serializer.sv
module sample_serializer #(
  parameter int DIV     = 4,
  parameter int MODE_W  = 4,
  parameter int HF_MODE = 3,
  parameter int WIDE    = 16,
  parameter int NARROW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE-1:0]   smp_word,
  input  logic              smp_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              ser_din,
  output logic              ser_clk,
  output logic              ser_frame,
  output logic              ser_dout,
  output logic [WIDE-1:0]   host_word,
  output logic              host_valid
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(WIDE + 1);
  localparam logic [MODE_W-1:0] HF_CODE = MODE_W'(HF_MODE);

  logic [CW-1:0]   cnt;
  logic [WIDE-1:0] hold, shreg, rx_sh;
  logic            hold_vld, active, wide;
  logic [BW-1:0]   left;

  wire rise     = (cnt == CW'(DIV - 1));
  wire fall     = (cnt == CW'(DIV / 2 - 1));
  wire in_word  = active && (left > BW'(1));
  wire load     = rise && !in_word && hold_vld;
  wire is_hf    = (mode == HF_CODE);
  wire [WIDE-1:0] rx_next = {rx_sh[WIDE-2:0], ser_din};

  assign ser_dout = active & shreg[WIDE-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      ser_clk    <= 1'b0;
      ser_frame  <= 1'b0;
      active     <= 1'b0;
      wide       <= 1'b0;
      left       <= '0;
      shreg      <= '0;
      rx_sh      <= '0;
      hold       <= '0;
      hold_vld   <= 1'b0;
      host_word  <= '0;
      host_valid <= 1'b0;
    end else begin
      cnt        <= rise ? '0 : cnt + CW'(1);
      host_valid <= 1'b0;
      if (rise) begin
        ser_clk <= 1'b1;
        if (in_word) begin
          shreg     <= shreg << 1;
          left      <= left - BW'(1);
          ser_frame <= 1'b0;
        end else if (hold_vld) begin
          wide      <= is_hf;
          shreg     <= is_hf ? hold : {hold[NARROW-1:0], {(WIDE-NARROW){1'b0}}};
          left      <= is_hf ? BW'(WIDE) : BW'(NARROW);
          active    <= 1'b1;
          ser_frame <= 1'b1;
        end else begin
          active    <= 1'b0;
          ser_frame <= 1'b0;
        end
      end
      if (fall) begin
        ser_clk <= 1'b0;
        if (active) begin
          rx_sh <= rx_next;
          if (left == BW'(1)) begin
            host_valid <= 1'b1;
            host_word  <= wide ? rx_next : {{(WIDE-NARROW){1'b0}}, rx_next[NARROW-1:0]};
          end
        end
      end
      if (smp_valid) begin
        hold     <= smp_word;
        hold_vld <= 1'b1;
      end else if (load) begin
        hold_vld <= 1'b0;
      end
    end
  end

  assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ser_frame) || !$stable(ser_dout)) |-> $rose(ser_clk));

  assert_frame_one_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_clk) && $past(ser_frame)) |-> !ser_frame);

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!ser_dout && !ser_frame));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> !host_valid);

  assert_strobe_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> !ser_clk);
endmodule

// File: tb/sample_serializer_tb.sv
module sample_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int HF = 3;

  logic clk = 0, rst_n = 0;
  logic [15:0] smp_word = '0;
  logic smp_valid = 0;
  logic [3:0] mode = '0;
  logic ser_din = 0;
  logic ser_clk, ser_frame, ser_dout, host_valid;
  logic [15:0] host_word;

  int errors = 0, checks = 0;
  string phase = "idle";

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_serializer #(.DIV(DIV), .MODE_W(4), .HF_MODE(HF)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_word(smp_word), .smp_valid(smp_valid),
    .mode(mode), .ser_din(ser_din), .ser_clk(ser_clk), .ser_frame(ser_frame),
    .ser_dout(ser_dout), .host_word(host_word), .host_valid(host_valid));

  // Reference model: a queue of the bits still to go in the current word
  bit q[$];
  int ph, rxn, rxlen;
  logic [15:0] rxacc, held, e_rxw;
  logic hv, e_clk, e_frame, e_dout, e_rxv;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; q.delete(); hv = 0; rxn = 0; rxlen = 0; rxacc = 0;
      e_clk = 0; e_frame = 0; e_dout = 0; e_rxv = 0; e_rxw = 0;
    end else begin
      e_rxv = 0;
      if (ph % DIV == DIV - 1) begin
        e_clk = 1;
        if (q.size() > 1) begin
          void'(q.pop_front()); e_frame = 0;
        end else if (hv) begin
          q.delete();
          rxlen = (mode == HF) ? 16 : 8;
          for (int i = rxlen - 1; i >= 0; i--) q.push_back(held[i]);
          hv = 0; e_frame = 1; rxn = 0; rxacc = 0;
        end else begin
          q.delete(); e_frame = 0;
        end
        e_dout = (q.size() > 0) ? q[0] : 1'b0;
      end
      if (ph % DIV == DIV/2 - 1) begin
        e_clk = 0;
        if (q.size() > 0 && rxn < rxlen) begin
          rxacc = {rxacc[14:0], ser_din}; rxn++;
          if (rxn == rxlen) begin e_rxv = 1; e_rxw = rxacc; end
        end
      end
      if (smp_valid) begin held = smp_word; hv = 1; end
      ph++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  int frames = 0, words = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ser_clk === e_clk, "R1 ser_clk", 16'(ser_clk), 16'(e_clk));
      chk(ser_frame === e_frame, "R4/R5 ser_frame", 16'(ser_frame), 16'(e_frame));
      chk(ser_dout === e_dout, (q.size() == 0) ? "R7 ser_dout idle" : "R3/R5 ser_dout",
          16'(ser_dout), 16'(e_dout));
      chk(host_valid === e_rxv, "R9 host_valid", 16'(host_valid), 16'(e_rxv));
      if (e_rxv) chk(host_word === e_rxw, "R9 host_word", host_word, e_rxw);
      if (ser_frame && $rose(ser_frame)) frames++;
      if (host_valid) words++;
    end
  end

  logic [15:0] lf = 16'hACE1;
  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    ser_din <= lf[0];
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk); smp_word = w; smp_valid = 1;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({ser_clk, ser_frame, ser_dout, host_valid} === 4'b0, "R2 reset outputs",
        16'({ser_clk, ser_frame, ser_dout, host_valid}), 16'h0);
    rst_n = 1;
    @(negedge clk);
    chk({ser_clk, ser_frame, ser_dout, host_valid} === 4'b0, "R2 after reset",
        16'({ser_clk, ser_frame, ser_dout, host_valid}), 16'h0);
    repeat (40) @(negedge clk);

    phase = "8-bit word R3"; mode = 4'd0; send(16'h3CA5); repeat (60) @(negedge clk);
    phase = "16-bit word R3"; mode = 4'(HF); send(16'hBEEF); repeat (90) @(negedge clk);

    phase = "mid-word mode change R6, back-to-back R8";
    send(16'h8143); repeat (20) @(negedge clk);
    mode = 4'd0; send(16'h7E5A); repeat (140) @(negedge clk);

    phase = "held word replaced R8";
    mode = 4'd5; send(16'h00C3); repeat (12) @(negedge clk);
    send(16'h0011); repeat (3) @(negedge clk);
    send(16'h0096); repeat (120) @(negedge clk);

    phase = "final idle R7"; repeat (30) @(negedge clk);
    chk(frames == 6, "R4/R8 frame count", 16'(frames), 16'd6);
    chk(words == 6, "R9/R8 received word count", 16'(words), 16'd6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule